// File: doc/BRIEF.md
# Power-Stage Fault Recovery Sequencer

This block supervises the protection line coming back from an output power stage. The line is active low and is pulled low when the stage detects an overcurrent or an overtemperature event. Once a fault is seen, the sequencer pulls a tri-state control line low. That low level tells the power stage to shut its outputs and begin recovery. After a fixed hold time of one millisecond, the sequencer releases the line high again.

After each release the sequencer waits a short settle interval and then looks at the fault line again. If the fault is still present, it issues another identical low pulse. If the fault has cleared, it goes back to idle. An interrupt output stays high for the whole recovery episode, so logic outside the block can see that the stage is in trouble.

The millisecond hold is counted in system clock cycles. The count is derived from a clock-frequency parameter, so a bench can use a small frequency and keep runs short. The fault line is asynchronous and passes through a two-flop synchronizer before it is used.

Top module: `pwr_fault_recovery`

## Requirements
- R1: A fault is a 0 on `fault_n_i`. When `fault_n_i` goes low ahead of a rising edge, `tri_ctl_o` reads 0 after the third rising edge counted from that one. Two edges are spent in the synchronizer and one in the state register. A pulse never starts while the synchronized fault line reads 1.
- R2: Every recovery pulse holds `tri_ctl_o` at 0 for exactly HOLD_CYC = (CLK_HZ / 1000) * HOLD_MS clock cycles, and then drives it back to 1.
- R3: After each release, `tri_ctl_o` stays at 1 for exactly SETTLE_CYC cycles. The synchronized fault line is then sampled again, and a further pulse follows at once if it still reads 0. A fault held at the input for D cycles (D >= 1) therefore yields exactly 1 + floor((D - 1) / (HOLD_CYC + SETTLE_CYC)) pulses.
- R4: `fault_irq_o` is 1 from the start of the first pulse until the block returns to idle. Whenever `tri_ctl_o` is 0, `fault_irq_o` is 1.
- R5: A pulse that has started runs to its full width even if the fault clears partway through it. A fault lasting a single cycle still produces one full pulse.
- R6: If the re-sample finds the fault clear, the block returns to idle with `tri_ctl_o` = 1 and `fault_irq_o` = 0. A later fault then starts a fresh sequence.
- R7: While `rst_n` is 0, and directly after it goes low (including in the middle of a pulse), `tri_ctl_o` is 1 and `fault_irq_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; its frequency is the CLK_HZ parameter |
| rst_n | input | 1 | Asynchronous active-low reset |
| fault_n_i | input | 1 | Asynchronous fault line from the power stage, 0 = fault |
| tri_ctl_o | output | 1 | Tri-state control to the power stage, 0 = force outputs off and recover |
| fault_irq_o | output | 1 | Fault interrupt, 1 while a recovery episode is under way |

## Verification
The hardest case to reach is the exact boundary of the re-sample window. There, the decision to pulse again depends on whether the synchronized fault line is still low at the last settle cycle. A shift of one cycle in the fault length flips the outcome. The stimulus holds the fault for lengths placed at and just beside each multiple of the pulse-plus-settle period, and for single-cycle and two-cycle glitches. It then counts the resulting pulses at the tri-state output. A reset applied in the middle of a pulse covers the abort path.

// File: rtl/pfr_pkg.sv
package pfr_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_PULSE  = 2'd1,
    PH_SETTLE = 2'd2
  } pfr_phase_e;

  // Cycles in the recovery hold, given the clock rate and the hold in ms.
  function automatic int unsigned hold_cycles(input int unsigned clk_hz,
                                              input int unsigned hold_ms);
    int unsigned per_ms;
    per_ms = clk_hz / 1000;
    if (per_ms == 0) per_ms = 1;
    return per_ms * hold_ms;
  endfunction

  // Counter width able to hold values up to and including lim.
  function automatic int unsigned cnt_width(input int unsigned lim);
    int unsigned w;
    w = 1;
    while ((lim >> w) != 0) w++;
    return w;
  endfunction

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/pfr_sync.sv
module pfr_sync #(
  parameter int unsigned STAGES = 2,
  parameter logic        IDLE_LVL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= IDLE_LVL;
          else        chain_q[g] <= din;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= IDLE_LVL;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/pfr_timer.sv
module pfr_timer #(
  parameter int unsigned HOLD_CYC   = 8,
  parameter int unsigned SETTLE_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic sel_hold,
  output logic hold_done,
  output logic settle_done
);
  localparam int unsigned TOP   = pfr_pkg::max_u(HOLD_CYC, SETTLE_CYC);
  localparam int unsigned CNT_W = pfr_pkg::cnt_width(TOP);
  localparam logic [CNT_W-1:0] HOLD_LAST   = CNT_W'(HOLD_CYC - 1);
  localparam logic [CNT_W-1:0] SETTLE_LAST = CNT_W'(SETTLE_CYC - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             at_hold_last;
  logic             at_settle_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (restart) cnt_q <= '0;
    else              cnt_q <= cnt_q + CNT_W'(1);
  end

  assign at_hold_last   = (cnt_q == HOLD_LAST);
  assign at_settle_last = (cnt_q == SETTLE_LAST);
  assign hold_done      = sel_hold & at_hold_last;
  assign settle_done    = ~sel_hold & at_settle_last;
endmodule

// File: rtl/pfr_fsm.sv
module pfr_fsm
  import pfr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       flt_act,
  input  logic       hold_done,
  input  logic       settle_done,
  output pfr_phase_e phase,
  output logic       restart,
  output logic       sel_hold
);
  pfr_phase_e phase_q, phase_d;

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_IDLE:   if (flt_act)     phase_d = PH_PULSE;
      PH_PULSE:  if (hold_done)   phase_d = PH_SETTLE;
      PH_SETTLE: if (settle_done) phase_d = flt_act ? PH_PULSE : PH_IDLE;
      default:                    phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_IDLE;
    else        phase_q <= phase_d;
  end

  assign phase    = phase_q;
  assign sel_hold = (phase_q == PH_PULSE);
  assign restart  = (phase_q == PH_IDLE) | hold_done | settle_done;
endmodule

// File: rtl/pwr_fault_recovery.sv
module pwr_fault_recovery #(
  parameter int unsigned CLK_HZ     = 49_152_000,
  parameter int unsigned HOLD_MS    = 1,
  parameter int unsigned SETTLE_CYC = 16,
  parameter int unsigned SYNC_STG   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fault_n_i,
  output logic tri_ctl_o,
  output logic fault_irq_o
);
  import pfr_pkg::*;

  localparam int unsigned HOLD_CYC = hold_cycles(CLK_HZ, HOLD_MS);

  logic       flt_n_sync;
  logic       flt_act;
  logic       hold_done;
  logic       settle_done;
  logic       restart;
  logic       sel_hold;
  pfr_phase_e phase;

  pfr_sync #(.STAGES(SYNC_STG), .IDLE_LVL(1'b1)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (fault_n_i),
    .dout (flt_n_sync)
  );

  assign flt_act = ~flt_n_sync;

  pfr_timer #(.HOLD_CYC(HOLD_CYC), .SETTLE_CYC(SETTLE_CYC)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .restart    (restart),
    .sel_hold   (sel_hold),
    .hold_done  (hold_done),
    .settle_done(settle_done)
  );

  pfr_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .flt_act    (flt_act),
    .hold_done  (hold_done),
    .settle_done(settle_done),
    .phase      (phase),
    .restart    (restart),
    .sel_hold   (sel_hold)
  );

  assign tri_ctl_o   = (phase != PH_PULSE);
  assign fault_irq_o = (phase != PH_IDLE);
endmodule

// File: rtl/pfr_checker.sv
module pfr_checker #(
  parameter int unsigned HOLD_CYC   = 8,
  parameter int unsigned SETTLE_CYC = 4
) (
  input logic clk,
  input logic rst_n,
  input logic tri_ctl,
  input logic irq,
  input logic flt_act
);
  logic [31:0] low_run;
  logic [31:0] high_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_run  <= '0;
      high_run <= '0;
    end else begin
      low_run  <= tri_ctl ? 32'd0 : low_run + 32'd1;
      high_run <= (tri_ctl && irq) ? high_run + 32'd1 : 32'd0;
    end
  end

  AST_START_NEEDS_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tri_ctl) |-> $past(flt_act)); // R1

  AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tri_ctl) |-> (low_run == HOLD_CYC)); // R2

  AST_SETTLE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(tri_ctl) && $past(irq)) |-> (high_run == SETTLE_CYC)); // R3

  AST_IRQ_COVERS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    !tri_ctl |-> irq); // R4

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> tri_ctl); // R6

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |-> (tri_ctl && !irq)); // R7
endmodule

bind pwr_fault_recovery pfr_checker #(
  .HOLD_CYC  (HOLD_CYC),
  .SETTLE_CYC(SETTLE_CYC)
) u_pfr_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .tri_ctl(tri_ctl_o),
  .irq    (fault_irq_o),
  .flt_act(flt_act)
);

// File: tb/test_pwr_fault_recovery.sv
module test_pwr_fault_recovery;
  localparam int CLK_PERIOD = 10;
  localparam int CLK_HZ     = 8000;
  localparam int SETTLE     = 3;
  localparam int HOLD       = CLK_HZ / 1000;   // one millisecond in cycles
  localparam int PERIOD     = HOLD + SETTLE;
  localparam int NCASE      = 8;
  // {fault length in cycles, expected pulse count}
  localparam int TBL [NCASE][2] = '{
    '{1, 1}, '{2, 1}, '{10, 1}, '{11, 1},
    '{12, 2}, '{23, 3}, '{30, 3}, '{45, 5}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fault_n = 1'b1;
  logic tri_ctl;
  logic irq;
  int   n_chk = 0;
  int   n_bad = 0;
  int   cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_fault_recovery #(.CLK_HZ(CLK_HZ), .HOLD_MS(1), .SETTLE_CYC(SETTLE)) i_pwr_fault_recovery (
    .clk        (clk),
    .rst_n      (rst_n),
    .fault_n_i  (fault_n),
    .tri_ctl_o  (tri_ctl),
    .fault_irq_o(irq)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  // Hold the fault for dur cycles and observe the full episode.
  task automatic run_case(input int dur, input int exp_pulses);
    int pulses = 0, low_run = 0, high_run = 0, bad_w = 0, bad_g = 0, irq_bad = 0;
    bit prev_tri = 1'b1;
    int window = dur + (exp_pulses + 2) * PERIOD + 6;
    @(negedge clk);
    fault_n = 1'b0;
    for (int k = 1; k <= window; k++) begin
      @(negedge clk);
      if (k == 2) check(tri_ctl == 1'b1, "R1 early", tri_ctl, 1);
      if (k == 3) check(tri_ctl == 1'b0, "R1 latency", tri_ctl, 0);
      if (!tri_ctl && !irq) irq_bad++;
      if (!tri_ctl) begin
        if (prev_tri) begin
          if (pulses > 0 && high_run != SETTLE) bad_g++;
          pulses++;
        end
        low_run++;
        high_run = 0;
      end else begin
        if (!prev_tri && low_run != HOLD) bad_w++;
        if (!prev_tri) low_run = 0;
        if (irq) high_run++;
      end
      prev_tri = tri_ctl;
      if (k == dur) fault_n = 1'b1;
    end
    check(bad_w == 0, "R2 width (R5 when fault ends early)", bad_w, 0);
    check(bad_g == 0, "R3 settle gap", bad_g, 0);
    check(pulses == exp_pulses, "R3 pulse count", pulses, exp_pulses);
    check(irq_bad == 0, "R4 irq while low", irq_bad, 0);
    check(tri_ctl == 1'b1 && irq == 1'b0, "R6 idle after clear", {tri_ctl, irq}, 2);
  endtask

  initial begin : watchdog
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual %0d expected <100000 cycles", cyc);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(tri_ctl == 1'b1 && irq == 1'b0, "R7 in reset", {tri_ctl, irq}, 2);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(tri_ctl == 1'b1 && irq == 1'b0, "R6 idle no fault", {tri_ctl, irq}, 2);

    for (int i = 0; i < NCASE; i++) begin
      run_case(TBL[i][0], TBL[i][1]);
      repeat (3) @(negedge clk);
    end

    // R5: a one-cycle glitch still gives a pulse of full width
    @(negedge clk);
    fault_n = 1'b0;
    @(negedge clk);
    fault_n = 1'b1;
    repeat (2) @(negedge clk);
    repeat (HOLD - 1) @(negedge clk);
    check(tri_ctl == 1'b0, "R5 glitch pulse last low cycle", tri_ctl, 0);
    @(negedge clk);
    check(tri_ctl == 1'b1, "R5 glitch pulse released", tri_ctl, 1);
    repeat (PERIOD) @(negedge clk);

    // R7: reset in the middle of a pulse
    fault_n = 1'b0;
    repeat (5) @(negedge clk);
    check(tri_ctl == 1'b0, "R7 setup pulse active", tri_ctl, 0);
    rst_n = 1'b0;
    #1;
    check(tri_ctl == 1'b1 && irq == 1'b0, "R7 reset mid-pulse", {tri_ctl, irq}, 2);
    fault_n = 1'b1;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(tri_ctl == 1'b1 && irq == 1'b0, "R7 quiet after reset", {tri_ctl, irq}, 2);

    // R6: a fresh fault after idle starts a new sequence
    run_case(5, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule